// File: doc/BRIEF.md
# Rotating-priority vectored interrupt controller

This block is the arbitration and vectoring core of a 16-source interrupt controller. Upstream capture logic hands it one-cycle set and clear pulses for the pending bits, plus each source's trigger mode. The core holds the pending, mask, in-service, cascade and start-of-scan registers. It also holds a vector base and a mode bit. From these it drives an active-low, registered interrupt request to the processor. Every register is read and written a byte at a time through a small synchronous port.

Two strobes stand in for the side-effect reads. `ack_i` picks a winner, returns its vector, marks it in service and clears its pending bit. `ret_i` returns the vector of the highest-ranked in-service source and retires it. Ranking is a circular scan. It starts at the one-hot start bit and moves toward higher source numbers, wrapping from 15 to 0.

Two modes exist. Auto-rotate mode moves the start bit on every acknowledge and return. Fixed mode keeps the start bit and allows nesting. In fixed mode, cascade sources count nested acknowledges, so the in-service bit of a cascade source stays set until every nested service has returned.

Top module: `prv_core`

## Requirements
- R1: After reset the mask reads 0xFF/0xFF, the start-of-scan register reads 0x01 (low byte) and 0x00 (high byte), and pending and in-service read zero. `irq_no` is high and the mode is auto-rotate (mode register bit 0 = 0).
- R2: The register map is as follows.
  - Address 0/1: pending (low/high byte).
  - Address 2/3: mask.
  - Address 4/5: in-service.
  - Address 6/7: cascade.
  - Address 8/9: start-of-scan. A write to address 8 sets it to 1 << data[3:0]; a write to address 9 is ignored.
  - Address 10: vector base, which keeps only data[7:4] and reads 0 in the low nibble.
  - Address 11: mode, where bit 0 = 1 selects fixed mode.
- R3: The acknowledge winner is the first source, scanning from the start bit toward higher numbers with wrap, that is pending with mask bit 0. A mask bit of 1 blocks its source.
- R4: An acknowledge produces a vector on `vec_o`, with `vec_vld_o` high, one cycle after `ack_i`. The vector is {base[7:4], number} for a normal source and {4'hF, number} for a cascade source. On that cycle the winner is in service, its pending bit is clear and `irq_no` is high.
- R5: An acknowledge that finds no unmasked pending source returns {base[7:4], 4'hF}. It clears pending bit 15 when `trig_level_i[15]` is 0 (edge mode). In auto-rotate mode it also clears the start-of-scan register to zero.
- R6: In auto-rotate mode, `irq_no` goes low two clock edges after the pending pulse, but only when an unmasked source is pending and nothing is in service.
- R7: In auto-rotate mode, an acknowledge moves the start bit to the winner, and a return rotates the start bit one place toward higher numbers.
- R8: In fixed mode the request is raised when nothing is in service and an unmasked source is pending. It is also raised when an unmasked pending source ranks above every in-service source. A lower-ranked one does not raise it, and the start bit does not move.
- R9: In fixed mode, a pending unmasked cascade source at the same rank as the highest in-service source raises the request again.
- R10: In fixed mode, a cascade source's nesting count rises on each acknowledge and falls on each return, and its in-service bit clears only when the count reaches zero. Writing its cascade bit to 0 clears the count.
- R11: A return yields the vector of the highest-ranked in-service source with the R4 encoding, and {base[7:4], 4'hF} when nothing is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pend_set_i | input | 16 | One-cycle pending set pulses |
| pend_clr_i | input | 16 | One-cycle pending clear pulses |
| trig_level_i | input | 16 | Per source: 1 level, 0 edge trigger |
| ack_i | input | 1 | Acknowledge strobe |
| ret_i | input | 1 | Return strobe |
| vec_o | output | 8 | Vector of the last acknowledge/return |
| vec_vld_o | output | 1 | vec_o updated this cycle |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench places the start bit mid-range with a masked source in the wrapped part. A scan that does not wrap, or that ignores the mask, would then pick the wrong vector. It retires a source in auto-rotate mode and expects the start bit one place higher; a design that rotated the wrong way or left it in place would then rank the next acknowledge differently. In fixed mode it stacks a higher-ranked source over a lower one and checks that a lower-ranked arrival stays silent. It nests a cascade source twice and expects its in-service bit to outlive the first return. It then clears the cascade bit mid-service, and a design that kept a stale count would leave that source stuck in service.

// File: rtl/prv_pkg.sv
package prv_pkg;
  typedef enum logic [3:0] {
    A_PEND_L = 4'd0,  A_PEND_H = 4'd1,
    A_MASK_L = 4'd2,  A_MASK_H = 4'd3,
    A_ISRV_L = 4'd4,  A_ISRV_H = 4'd5,
    A_CASC_L = 4'd6,  A_CASC_H = 4'd7,
    A_FP_L   = 4'd8,  A_FP_H   = 4'd9,
    A_BASE   = 4'd10, A_MODE   = 4'd11
  } prv_reg_e;

  localparam logic [3:0] CASC_HI = 4'hF;
endpackage

// File: rtl/prv_prio_scan.sv
module prv_prio_scan #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     start_i,
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] s;
  logic [IDX_W-1:0] k;
  logic [2*N-1:0]   dbl;
  logic [N-1:0]     rot;

  always_comb begin
    s = '0;
    for (int i = 0; i < N; i++)
      if (start_i[i]) s = IDX_W'(i);
    dbl = {req_i, req_i} >> s;
    rot = dbl[N-1:0];
    k = '0;
    for (int i = N - 1; i >= 0; i--)
      if (rot[i]) k = IDX_W'(i);
    found_o = (|rot) && (|start_i);
    idx_o   = s + k;  // wraps modulo N
  end
endmodule

// File: rtl/prv_nest_cnt.sv
module prv_nest_cnt #(
  parameter int N     = 16,
  parameter int CNT_W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] inc_i,
  input  logic [N-1:0] dec_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] last_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        cnt_q <= '0;
      else if (clr_i[g])                  cnt_q <= '0;
      else if (inc_i[g] && !dec_i[g]) begin
        if (cnt_q != CNT_MAX)             cnt_q <= cnt_q + 1'b1;
      end else if (dec_i[g] && !inc_i[g]) begin
        if (cnt_q != '0)                  cnt_q <= cnt_q - 1'b1;
      end
    end
    assign last_o[g] = (cnt_q <= CNT_W'(1));

    // R10
    nest_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i[g] && !inc_i[g] && !clr_i[g] && cnt_q == '0) |=> cnt_q == '0);
  end
endmodule

// File: rtl/prv_core.sv
module prv_core
  import prv_pkg::*;
#(
  parameter int N     = 16,
  parameter int CNT_W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [3:0]   addr_i,
  input  logic [7:0]   wdata_i,
  output logic [7:0]   rdata_o,
  input  logic [N-1:0] pend_set_i,
  input  logic [N-1:0] pend_clr_i,
  input  logic [N-1:0] trig_level_i,
  input  logic         ack_i,
  input  logic         ret_i,
  output logic [7:0]   vec_o,
  output logic         vec_vld_o,
  output logic         irq_no
);
  localparam int IDX_W = $clog2(N);
  localparam int HB    = N / 2;

  logic [N-1:0] pend_q, mask_q, isrv_q, casc_q, fp_q;
  logic [N-1:0] pend_d, mask_d, isrv_d, casc_d, fp_d;
  logic [3:0]   base_q, base_d;
  logic         fixed_q, fixed_d;
  logic         irq_q, want;
  logic [7:0]   vec_q, vec_d;
  logic         vld_q;

  logic [N-1:0] up;
  assign up = pend_q & ~mask_q;

  logic             win_found, srv_found, hit_found;
  logic [IDX_W-1:0] win_idx, srv_idx, hit_idx;

  prv_prio_scan #(.N(N)) u_scan_win (
    .start_i(fp_q), .req_i(up), .found_o(win_found), .idx_o(win_idx));
  prv_prio_scan #(.N(N)) u_scan_srv (
    .start_i(fp_q), .req_i(isrv_q), .found_o(srv_found), .idx_o(srv_idx));
  prv_prio_scan #(.N(N)) u_scan_hit (
    .start_i(fp_q), .req_i(isrv_q | up), .found_o(hit_found), .idx_o(hit_idx));

  logic [N-1:0] n_inc, n_dec, n_clr, n_last;

  prv_nest_cnt #(.N(N), .CNT_W(CNT_W)) u_nest (
    .clk_i, .rst_ni, .inc_i(n_inc), .dec_i(n_dec), .clr_i(n_clr), .last_o(n_last));

  function automatic logic [7:0] mk_vec(input logic c, input logic [3:0] b,
                                        input logic [IDX_W-1:0] n);
    return c ? {CASC_HI, 4'(n)} : {b, 4'(n)};
  endfunction

  // request qualification
  always_comb begin
    if (isrv_q == '0)  want = |up;
    else if (!fixed_q) want = 1'b0;
    else if (!hit_found) want = 1'b0;
    else if (!isrv_q[hit_idx]) want = 1'b1;
    else want = casc_q[hit_idx] & up[hit_idx];
  end

  wire wr_lo = wr_i;
  always_comb begin
    pend_d = pend_q; mask_d = mask_q; isrv_d = isrv_q; casc_d = casc_q;
    fp_d = fp_q; base_d = base_q; fixed_d = fixed_q; vec_d = vec_q;
    n_inc = '0; n_dec = '0; n_clr = '0;

    if (wr_lo) begin
      case (prv_reg_e'(addr_i))
        A_PEND_L: pend_d[HB-1:0] = wdata_i;
        A_PEND_H: pend_d[N-1:HB] = wdata_i;
        A_MASK_L: mask_d[HB-1:0] = wdata_i;
        A_MASK_H: mask_d[N-1:HB] = wdata_i;
        A_ISRV_L: isrv_d[HB-1:0] = wdata_i;
        A_ISRV_H: isrv_d[N-1:HB] = wdata_i;
        A_CASC_L: begin
          casc_d[HB-1:0] = wdata_i;
          n_clr[HB-1:0]  = ~wdata_i;
        end
        A_CASC_H: begin
          casc_d[N-1:HB] = wdata_i;
          n_clr[N-1:HB]  = ~wdata_i;
        end
        A_FP_L:   fp_d = N'(1) << wdata_i[IDX_W-1:0];
        A_BASE:   base_d = wdata_i[7:4];
        A_MODE:   fixed_d = wdata_i[0];
        default: ;
      endcase
    end

    pend_d = (pend_d & ~pend_clr_i) | pend_set_i;

    if (ack_i) begin
      if (win_found) begin
        pend_d[win_idx] = 1'b0;
        isrv_d[win_idx] = 1'b1;
        vec_d = mk_vec(casc_q[win_idx], base_q, win_idx);
        if (fixed_q) n_inc[win_idx] = casc_q[win_idx];
        else         fp_d = N'(1) << win_idx;
      end else begin
        vec_d = {base_q, 4'hF};
        if (!trig_level_i[N-1]) pend_d[N-1] = 1'b0;
        if (!fixed_q) fp_d = '0;
      end
    end

    if (ret_i) begin
      if (srv_found) begin
        vec_d = mk_vec(casc_q[srv_idx], base_q, srv_idx);
        if (fixed_q && casc_q[srv_idx]) begin
          n_dec[srv_idx] = 1'b1;
          if (n_last[srv_idx]) isrv_d[srv_idx] = 1'b0;
        end else begin
          isrv_d[srv_idx] = 1'b0;
        end
      end else begin
        vec_d = {base_q, 4'hF};
      end
      if (!fixed_q) fp_d = {fp_d[N-2:0], fp_d[N-1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0; mask_q <= '1; isrv_q <= '0; casc_q <= '0;
      fp_q <= N'(1); base_q <= '0; fixed_q <= 1'b0;
      irq_q <= 1'b0; vec_q <= '0; vld_q <= 1'b0;
    end else begin
      pend_q <= pend_d; mask_q <= mask_d; isrv_q <= isrv_d; casc_q <= casc_d;
      fp_q <= fp_d; base_q <= base_d; fixed_q <= fixed_d;
      irq_q <= ack_i ? 1'b0 : want;  // one acknowledge per request edge
      vec_q <= vec_d;
      vld_q <= ack_i | ret_i;
    end
  end

  always_comb begin
    case (prv_reg_e'(addr_i))
      A_PEND_L: rdata_o = pend_q[HB-1:0];
      A_PEND_H: rdata_o = pend_q[N-1:HB];
      A_MASK_L: rdata_o = mask_q[HB-1:0];
      A_MASK_H: rdata_o = mask_q[N-1:HB];
      A_ISRV_L: rdata_o = isrv_q[HB-1:0];
      A_ISRV_H: rdata_o = isrv_q[N-1:HB];
      A_CASC_L: rdata_o = casc_q[HB-1:0];
      A_CASC_H: rdata_o = casc_q[N-1:HB];
      A_FP_L:   rdata_o = fp_q[HB-1:0];
      A_FP_H:   rdata_o = fp_q[N-1:HB];
      A_BASE:   rdata_o = {base_q, 4'h0};
      A_MODE:   rdata_o = {7'd0, fixed_q};
      default:  rdata_o = 8'h00;
    endcase
  end

  assign vec_o     = vec_q;
  assign vec_vld_o = vld_q;
  assign irq_no    = ~irq_q;

  // R4
  irq_drop_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> irq_no);
  // R4
  ack_marks_srv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && win_found) |=> (isrv_q != '0) && vec_vld_o);
  // R6
  auto_idle_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_q) && !$past(fixed_q)) |-> ($past(isrv_q) == '0));
  // R7
  fp_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fp_q));
  // R5
  empty_ack_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !win_found && !ret_i) |=> vec_o[3:0] == 4'hF);
endmodule

// File: tb/prv_core_tb_top.sv
`timescale 1ns/1ps
module prv_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] pset = '0, pclr = '0, tlev = '0;
  logic        ack = 1'b0, ret = 1'b0;
  logic [7:0]  vec;
  logic        vld, irq_n;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  prv_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pend_set_i(pset), .pend_clr_i(pclr), .trig_level_i(tlev),
    .ack_i(ack), .ret_i(ret), .vec_o(vec), .vec_vld_o(vld), .irq_no(irq_n));

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd_reg(a, lo); rd_reg(a + 4'd1, hi); d = {hi, lo};
  endtask

  task automatic pulse_set(input logic [15:0] m);
    @(negedge clk); pset = m;
    @(negedge clk); pset = '0;
    @(negedge clk);  // request register settles
  endtask

  task automatic do_ack(input string r, input logic [7:0] exp);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk({r, " ack vector"}, {8'h0, vec}, {8'h0, exp});
    chk({r, " ack valid"}, vld, 1'b1);
    chk({r, " irq dropped"}, irq_n, 1'b1);
  endtask

  task automatic do_ret(input string r, input logic [7:0] exp);
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
    chk({r, " ret vector"}, {8'h0, vec}, {8'h0, exp});
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd16(4'd2, v);  chk("R1 mask", v, 16'hFFFF);
    rd16(4'd8, v);  chk("R1 first", v, 16'h0001);
    rd16(4'd0, v);  chk("R1 pend", v, 16'h0000);
    rd16(4'd4, v);  chk("R1 isrv", v, 16'h0000);
    chk("R1 irq", irq_n, 1'b1);
  endtask

  task automatic t_regs;
    logic [7:0] b; logic [15:0] v;
    wr_reg(4'd10, 8'hA7); rd_reg(4'd10, b); chk("R2 base nibble", b, 8'hA0);
    wr_reg(4'd8, 8'h13);  rd16(4'd8, v);    chk("R2 first write", v, 16'h0008);
    wr_reg(4'd9, 8'h55);  rd16(4'd8, v);    chk("R2 first hi ignored", v, 16'h0008);
    wr_reg(4'd2, 8'h00); wr_reg(4'd3, 8'h00);
    rd16(4'd2, v); chk("R2 mask", v, 16'h0000);
    wr_reg(4'd8, 8'h00);
  endtask

  task automatic t_auto;
    logic [15:0] v;
    pulse_set(16'h0208);
    chk("R6 irq raised", irq_n, 1'b0);
    do_ack("R4", 8'hA3);
    rd16(4'd0, v); chk("R4 pend cleared", v, 16'h0200);
    rd16(4'd4, v); chk("R4 in service", v, 16'h0008);
    rd16(4'd8, v); chk("R7 first follows ack", v, 16'h0008);
    @(negedge clk); chk("R6 held while in service", irq_n, 1'b1);
    do_ret("R11", 8'hA3);
    rd16(4'd8, v); chk("R7 rotate on return", v, 16'h0010);
    rd16(4'd4, v); chk("R11 retired", v, 16'h0000);
    chk("R6 irq re-raised", irq_n, 1'b0);
    do_ack("R3", 8'hA9);
    do_ret("R11", 8'hA9);
    // wrap with mask
    wr_reg(4'd8, 8'h0A);
    wr_reg(4'd2, 8'h04);
    pulse_set(16'h0024);
    do_ack("R3 wrap masked", 8'hA5);
    do_ret("R3", 8'hA5);
    wr_reg(4'd2, 8'h00);
    wr_reg(4'd8, 8'h00);
    do_ack("R3 unmasked", 8'hA2);
    do_ret("R3", 8'hA2);
  endtask

  task automatic t_empty;
    logic [15:0] v;
    wr_reg(4'd8, 8'h00);
    wr_reg(4'd3, 8'h80);
    pulse_set(16'h8000);
    chk("R6 masked no irq", irq_n, 1'b1);
    do_ack("R5", 8'hAF);
    rd16(4'd0, v); chk("R5 edge 15 cleared", v, 16'h0000);
    rd16(4'd8, v); chk("R5 first cleared", v, 16'h0000);
    do_ret("R11 none", 8'hAF);
    wr_reg(4'd3, 8'h00);
    wr_reg(4'd8, 8'h00);
  endtask

  task automatic t_fixed;
    logic [15:0] v;
    wr_reg(4'd11, 8'h01);
    pulse_set(16'h0020);
    chk("R8 idle raise", irq_n, 1'b0);
    do_ack("R8", 8'hA5);
    pulse_set(16'h0080);
    chk("R8 lower rank silent", irq_n, 1'b1);
    pulse_set(16'h0004);
    chk("R8 higher rank raises", irq_n, 1'b0);
    do_ack("R8", 8'hA2);
    rd16(4'd4, v); chk("R8 nested", v, 16'h0024);
    do_ret("R11 highest", 8'hA2);
    @(negedge clk); chk("R8 still lower", irq_n, 1'b1);
    do_ret("R11", 8'hA5);
    @(negedge clk); chk("R8 raise after return", irq_n, 1'b0);
    do_ack("R8", 8'hA7);
    do_ret("R8", 8'hA7);
    rd16(4'd8, v); chk("R8 first fixed", v, 16'h0001);
  endtask

  task automatic t_casc;
    logic [15:0] v;
    wr_reg(4'd6, 8'h10);
    pulse_set(16'h0010);
    do_ack("R4 cascade", 8'hF4);
    pulse_set(16'h0010);
    chk("R9 same rank raises", irq_n, 1'b0);
    do_ack("R9", 8'hF4);
    do_ret("R10", 8'hF4);
    rd16(4'd4, v); chk("R10 kept in service", v, 16'h0010);
    do_ret("R10", 8'hF4);
    rd16(4'd4, v); chk("R10 released", v, 16'h0000);
    pulse_set(16'h0010);
    do_ack("R10", 8'hF4);
    wr_reg(4'd6, 8'h00);
    do_ret("R10 count cleared", 8'hA4);
    rd16(4'd4, v); chk("R10 cleared release", v, 16'h0000);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_auto();
    t_empty();
    t_fixed();
    t_casc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule